// File: doc/BRIEF.md
# DRAM Refresh and Initialization Controller

This controller sits on the host side of a 1024-row dynamic memory and owns its three control strobes: row strobe, column strobe and write enable. After reset it holds every strobe inactive for a power-up pause. It then issues a burst of wake-up refresh cycles, and only after that does it declare itself ready for host traffic.

From then on a refresh timer raises a pending flag at a fixed interval. The default interval spreads 1024 refreshes across each 16 ms period, which is about one every 15.6 us. Every refresh is a counter-based cycle: the column strobe drops before the row strobe, so the memory supplies the row address internally.

Host reads and writes arrive on a level request held until a one-cycle acknowledge. Each one runs as a single row/column access. An `addr_col` output tells the external address multiplexer when to present the column half. All timings are counted in clock cycles and set through parameters.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high (inactive), and `ready` and `ack` are low.
- R2: After reset is released, neither strobe goes low for at least PAUSE_CYC cycles. The first column-strobe fall comes no later than PAUSE_CYC+6 cycles after release.
- R3: After the pause, exactly WAKE_REFS refresh cycles are issued before `ready` rises. Once high, `ready` stays high until reset.
- R4: In a refresh cycle, `cas_n` falls while `ras_n` is high. It stays low for T_CSR cycles before `ras_n` falls and for T_CHR cycles after, so its total low time is T_CSR+T_CHR. `we_n` stays high throughout.
- R5: `ras_n` stays low for exactly T_RAS cycles in a refresh and exactly T_RCD+T_CAS cycles in a host access. It never stays low longer than MAX_RAS_CYC cycles.
- R6: Between any two low periods, `ras_n` stays high for at least T_RP cycles.
- R7: After `ready`, the start of each refresh (the `cas_n` fall with `ras_n` high) lies within REF_INTERVAL ± (T_RCD+T_CAS+T_RP+2) cycles of the previous one, even under continuous host traffic.
- R8: A host access proceeds in this order. First `ras_n` falls with `addr_col`=0. T_RCD cycles later `cas_n` falls with `addr_col`=1. `we_n` is low for the whole column phase when `wr`=1 was presented at acceptance, and high when `wr`=0. `ack` is high for one cycle, the last cycle of the column phase, while both strobes are low.
- R9: When a refresh is pending, it is started before any waiting host request. An access already begun runs to completion with `ras_n` held low throughout.
- R10: A request presented before `ready` rises is not serviced: `ack` is never high while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Host access request, held until `ack` |
| wr | input | 1 | 1 = write, 0 = read; sampled when the request is accepted |
| ack | output | 1 | One-cycle pulse at the end of the access column phase |
| ready | output | 1 | High once initialization has completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr_col | output | 1 | 1 selects the column half of the address, 0 the row half |

## Verification
The assertions assume that the host keeps `req` and `wr` stable from the cycle it raises a request until it sees `ack`. They also assume that the timing parameters satisfy T_RAS > T_CHR, every duration is at least one cycle, and REF_INTERVAL exceeds the longest cycle pair.

The bench drives the host pins only on falling clock edges and drops or replaces a request in the cycle that `ack` is seen. It runs a long stream of back-to-back alternating writes and reads, so that pending refreshes must win arbitration. Every strobe edge is timed by a cycle-counting monitor, which compares it with widths derived arithmetically from the parameters.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_RF_CAS,
    ST_RF_HOLD,
    ST_RF_RAS,
    ST_PRE,
    ST_ROW,
    ST_COL
  } seq_state_e;
endpackage

// File: rtl/dram_rc_pause.sv
module dram_rc_pause #(
  parameter int PAUSE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int PW = $clog2(PAUSE_CYC + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign cnt_en = !done_q;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    done_d = (cnt_q == PW'(PAUSE_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/dram_rc_ref_timer.sv
module dram_rc_ref_timer #(
  parameter int REF_INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic take,
  output logic pend
);
  localparam int IW = $clog2(REF_INTERVAL + 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = (cnt_q == IW'(REF_INTERVAL - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (take)        pend_d = 1'b0;
    if (run && wrap) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (run) cnt_q <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/dram_rc_seq.sv
module dram_rc_seq
  import dram_rc_pkg::*;
#(
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 3,
  parameter int WAKE_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic ref_pend,
  input  logic req,
  input  logic wr,
  output logic ref_take,
  output logic ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic addr_col,
  output logic ack
);
  localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int M3   = (M2 > T_CAS) ? M2 : T_CAS;
  localparam int MAXD = (M1 > M3) ? M1 : M3;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int WW   = $clog2(WAKE_REFS + 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          rdy_q, rdy_d;
  logic          wr_q, wr_d;
  logic          last;

  function automatic logic [CW-1:0] dur_of(seq_state_e s);
    case (s)
      ST_RF_CAS:  dur_of = CW'(T_CSR - 1);
      ST_RF_HOLD: dur_of = CW'(T_CHR - 1);
      ST_RF_RAS:  dur_of = CW'(T_RAS - T_CHR - 1);
      ST_PRE:     dur_of = CW'(T_RP - 1);
      ST_ROW:     dur_of = CW'(T_RCD - 1);
      ST_COL:     dur_of = CW'(T_CAS - 1);
      default:    dur_of = '0;
    endcase
  endfunction

  assign last = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    wake_d = wake_q;
    rdy_d  = rdy_q;
    wr_d   = wr_q;
    case (st_q)
      ST_PAUSE:   if (pause_done) st_d = ST_RF_CAS;
      ST_IDLE: begin
        if (ref_pend) begin
          st_d = ST_RF_CAS;
        end else if (req) begin
          st_d = ST_ROW;
          wr_d = wr;
        end
      end
      ST_RF_CAS:  if (last) st_d = ST_RF_HOLD;
      ST_RF_HOLD: if (last) st_d = ST_RF_RAS;
      ST_RF_RAS:  if (last) st_d = ST_PRE;
      ST_PRE: begin
        if (last) begin
          if (rdy_q) begin
            st_d = ST_IDLE;
          end else if (wake_q == WW'(WAKE_REFS - 1)) begin
            st_d  = ST_IDLE;
            rdy_d = 1'b1;
          end else begin
            st_d   = ST_RF_CAS;
            wake_d = wake_q + 1'b1;
          end
        end
      end
      ST_ROW:     if (last) st_d = ST_COL;
      ST_COL:     if (last) st_d = ST_PRE;
      default:    st_d = ST_IDLE;
    endcase
    if (st_d != st_q) cnt_d = dur_of(st_d);
    else if (!last)   cnt_d = cnt_q - 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      cnt_q  <= '0;
      wake_q <= '0;
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wake_q <= wake_d;
      rdy_q  <= rdy_d;
      wr_q   <= wr_d;
    end
  end

  assign ref_take = (st_q == ST_IDLE) && ref_pend;
  assign ready    = rdy_q;
  assign ras_n    = !((st_q == ST_RF_HOLD) || (st_q == ST_RF_RAS) ||
                      (st_q == ST_ROW)     || (st_q == ST_COL));
  assign cas_n    = !((st_q == ST_RF_CAS) || (st_q == ST_RF_HOLD) ||
                      (st_q == ST_COL));
  assign we_n     = !((st_q == ST_COL) && wr_q);
  assign addr_col = (st_q == ST_COL);
  assign ack      = (st_q == ST_COL) && last;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int PAUSE_CYC    = 10000,
  parameter int WAKE_REFS    = 8,
  parameter int REF_INTERVAL = 780,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 3,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int MAX_RAS_CYC  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic ack,
  output logic ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic addr_col
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       pause_done;
  logic       ref_pend;
  logic       ref_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dram_rc_pause #(.PAUSE_CYC(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst_n(rst_int_n),
    .done (pause_done)
  );

  dram_rc_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (ready),
    .take (ref_take),
    .pend (ref_pend)
  );

  dram_rc_seq #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .WAKE_REFS(WAKE_REFS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pause_done(pause_done),
    .ref_pend  (ref_pend),
    .req       (req),
    .wr        (wr),
    .ref_take  (ref_take),
    .ready     (ready),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr_col  (addr_col),
    .ack       (ack)
  );
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int T_RP        = 4,
  parameter int MAX_RAS_CYC = 500
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ack,
  input logic ready
);
  localparam int SW = $clog2(MAX_RAS_CYC + T_RP + 2);
  localparam logic [SW-1:0] SAT = SW'(MAX_RAS_CYC + T_RP + 1);

  logic [SW-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= SAT;
      lo_q <= '0;
    end else begin
      if (ras_n) begin
        hi_q <= (hi_q == SAT) ? hi_q : hi_q + 1'b1;
        lo_q <= '0;
      end else begin
        hi_q <= '0;
        lo_q <= (lo_q == SAT) ? lo_q : lo_q + 1'b1;
      end
    end
  end

  // R4
  cbr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n) && !cas_n) |-> !$past(cas_n));

  // R4
  cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> we_n);

  // R8
  ack_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!ras_n && !cas_n));

  // R10
  ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ready);

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_q >= SW'(T_RP)));

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_q <= SW'(MAX_RAS_CYC)));
endmodule

bind dram_refresh_ctrl dram_refresh_chk #(
  .T_RP(T_RP), .MAX_RAS_CYC(MAX_RAS_CYC)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .ras_n(ras_n),
  .cas_n(cas_n),
  .we_n (we_n),
  .ack  (ack),
  .ready(ready)
);

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
  localparam int PAUSE_CYC    = 10000;
  localparam int WAKE_REFS    = 8;
  localparam int REF_INTERVAL = 780;
  localparam int T_CSR        = 2;
  localparam int T_CHR        = 3;
  localparam int T_RAS        = 6;
  localparam int T_RP         = 4;
  localparam int T_RCD        = 2;
  localparam int T_CAS        = 3;
  localparam int MAX_RAS_CYC  = 500;
  localparam int SLACK        = T_RCD + T_CAS + T_RP + 2;

  logic clk, rst_n, req, wr;
  logic ack, ready, ras_n, cas_n, we_n, addr_col;

  int n_chk, n_fail;
  bit finished;

  dram_refresh_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_REFS(WAKE_REFS), .REF_INTERVAL(REF_INTERVAL),
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .MAX_RAS_CYC(MAX_RAS_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ack(ack), .ready(ready),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_col(addr_col)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  int  cyc, ras_lo, ras_hi, cas_lo, wake_seen, ref_cnt, last_ref;
  bit  ras_p, cas_p, rdy_p, cur_ref, seen_ras, seen_cas, have_last, exp_wr;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; ras_lo = 0; ras_hi = 0; cas_lo = 0; wake_seen = 0;
      ref_cnt = 0; last_ref = 0; ras_p = 1; cas_p = 1; rdy_p = 0;
      cur_ref = 0; seen_ras = 0; seen_cas = 0; have_last = 0;
    end else begin
      cyc++;
      if (ras_p && !ras_n) begin
        if (seen_ras) chk(ras_hi >= T_RP, "R6 precharge", ras_hi, T_RP);
        seen_ras = 1;
        cur_ref  = !cas_n;
        if (cur_ref) chk(cas_lo == T_CSR, "R4 cas setup", cas_lo, T_CSR);
        else         chk(addr_col == 1'b0, "R8 row phase addr_col", addr_col, 0);
      end
      if (!ras_p && ras_n)
        chk(ras_lo == (cur_ref ? T_RAS : T_RCD + T_CAS), "R5 ras width", ras_lo,
            cur_ref ? T_RAS : T_RCD + T_CAS);
      if (cas_p && !cas_n) begin
        if (ras_n) begin
          chk(we_n == 1'b1, "R4 we high in refresh", we_n, 1);
          if (!seen_cas)
            chk(cyc > PAUSE_CYC && cyc <= PAUSE_CYC + 6, "R2 pause", cyc, PAUSE_CYC);
          seen_cas = 1;
          if (ready) begin
            if (have_last)
              chk((cyc - last_ref) >= REF_INTERVAL - SLACK &&
                  (cyc - last_ref) <= REF_INTERVAL + SLACK,
                  "R7 R9 refresh spacing", cyc - last_ref, REF_INTERVAL);
            last_ref  = cyc;
            have_last = 1;
          end else begin
            wake_seen++;
          end
          ref_cnt++;
        end else begin
          chk(ras_lo == T_RCD, "R8 ras to cas delay", ras_lo, T_RCD);
          chk(addr_col == 1'b1, "R8 column addr_col", addr_col, 1);
          chk(we_n == !exp_wr, "R8 we_n level", we_n, !exp_wr);
        end
      end
      if (!cas_p && cas_n)
        chk(cas_lo == (cur_ref ? T_CSR + T_CHR : T_CAS), "R4 R8 cas width", cas_lo,
            cur_ref ? T_CSR + T_CHR : T_CAS);
      if (!rdy_p && ready)
        chk(wake_seen == WAKE_REFS, "R3 wake refresh count", wake_seen, WAKE_REFS);
      if (rdy_p)
        chk(ready == 1'b1, "R3 ready sticky", ready, 1);
      if (ack) begin
        chk(ready == 1'b1, "R10 ack before ready", ready, 1);
        chk(!ras_n && !cas_n, "R8 ack strobes", {ras_n, cas_n}, 0);
      end
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      ras_p = ras_n; cas_p = cas_n; rdy_p = ready;
    end
  end

  int acks;

  task automatic wait_ack(input string tag);
    int lim;
    lim = 0;
    @(negedge clk);
    while (!ack && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    chk(ack == 1'b1, tag, ack, 1);
    acks++;
  endtask

  task automatic single(input bit w);
    exp_wr = w;
    wr     = w;
    req    = 1'b1;
    wait_ack("R8 single access ack");
    req = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 0; acks = 0;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; exp_wr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ras_n == 1'b1, "R1 ras_n reset", ras_n, 1);
    chk(cas_n == 1'b1, "R1 cas_n reset", cas_n, 1);
    chk(we_n == 1'b1, "R1 we_n reset", we_n, 1);
    chk(ready == 1'b0, "R1 ready reset", ready, 0);
    chk(ack == 1'b0, "R1 ack reset", ack, 0);
    rst_n = 1'b1;
    // R10: request held during initialization
    exp_wr = 1'b1; wr = 1'b1; req = 1'b1;
    wait_ack("R10 first ack after ready");
    req = 1'b0;
    chk(ref_cnt == WAKE_REFS, "R10 no extra activity before ready", ref_cnt, WAKE_REFS);
    // R8 single accesses
    repeat (10) @(negedge clk);
    single(1'b0);
    repeat (5) @(negedge clk);
    single(1'b1);
    repeat (5) @(negedge clk);
    single(1'b0);
    // R9 continuous stream
    acks = 0;
    exp_wr = 1'b0; wr = 1'b0; req = 1'b1;
    for (int i = 0; i < 400; i++) begin
      wait_ack("R9 stream ack");
      exp_wr = ~exp_wr;
      wr     = exp_wr;
    end
    req = 1'b0;
    chk(acks == 400, "R9 stream ack count", acks, 400);
    // R7 idle refresh rate
    begin
      int r0;
      r0 = ref_cnt;
      repeat (6 * REF_INTERVAL) @(negedge clk);
      chk((ref_cnt - r0) >= 5 && (ref_cnt - r0) <= 7, "R7 idle refresh count",
          ref_cnt - r0, 6);
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule